// File: doc/BRIEF.md
# Tiled Depth-Stencil Pixel Access Unit

This block serves single-pixel read and write requests aimed at a depth surface. Each request carries pixel coordinates; a window origin is added, and the result becomes a byte address. The address comes from one of three maps. The first is a plain row-major layout. The other two are tiled layouts, one for 16-bit depth and one for 32-bit packed depth-stencil. The tiled maps interleave coordinate bits with the bits of a block index and fold some of them together with XOR. The unit drives one 32-bit synchronous memory port whose read data comes back one cycle after the read is issued.

In the 16-bit format a depth value fills one half of a memory word. A write therefore goes out at once with a byte-enable pair that selects that half. In the 32-bit packed format each word holds a 24-bit depth field in its low bits and an 8-bit stencil field in its top byte. A write to either field becomes a read followed by a merged write-back. During that sequence the unit shows busy and holds off new requests, so the other field is preserved. Reads return the selected field, zero-extended, one cycle after acceptance.

Top module: `zs_access_unit`

## Requirements
- R1: The effective coordinates are req_x + cfg_org_x and req_y + cfg_org_y, each taken modulo 2^CW, before any address mapping.
- R2: With cfg_linear = 1 the byte address is (x + y * cfg_pitch) multiplied by 4 when cfg_fmt32 = 1, or by 2 when cfg_fmt32 = 0.
- R3: With cfg_linear = 0 and cfg_fmt32 = 1 the block index is b = (y/16)*(cfg_pitch/16) + x/16. The address has bits [1:0] = 0, [4:2] = x[2:0], [6:5] = y[1:0], bit 7 = x[4]^y[2], [9:8] = b[1:0], bit 10 = y[3], bit 11 = x[3]^y[4], and bits 12 and up = b[2] and up.
- R4: With cfg_linear = 0 and cfg_fmt32 = 0 the block index is b = (y/16)*(cfg_pitch/32) + x/32. The address has bit 0 = 0, [3:1] = x[2:0], [6:4] = y[2:0], bit 7 = x[3], [9:8] = b[1:0], bit 10 = y[3], bit 11 = x[4]^y[4], and bits 12 and up = b[2] and up.
- R5: In the 16-bit format a write is issued in its acceptance cycle as one memory write, with no busy. mem_be is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. mem_wdata carries req_wdata[15:0] in both halves, so the other half of the word is left intact.
- R6: In the 32-bit format a depth write (req_stencil = 0) stores req_wdata[23:0] in bits [23:0] and keeps the stored bits [31:24].
- R7: In the 32-bit format a stencil write (req_stencil = 1) stores req_wdata[7:0] in bits [31:24] and keeps the stored bits [23:0].
- R8: An accepted read raises rd_valid for exactly one cycle, in the cycle after acceptance. rd_data is zero-extended and holds one of three things. In the 16-bit format it is the half selected by address bit 1 (1 selects [31:16]). For a 32-bit depth read it is bits [23:0]. For a 32-bit stencil read it is bits [31:24].
- R9: A 32-bit write issues nothing in its acceptance cycle. The next cycle is a read of the target word, and the cycle after that is a write of the target word with mem_be = 4'hF. busy is high and req_ready is low through both cycles, and a request held valid in that time is accepted only once busy falls.
- R10: In the 16-bit format req_stencil has no effect on reads or writes.
- R11: During and right after reset, busy = 0, req_ready = 1, rd_valid = 0, and mem_en = 0 while req_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_stencil | input | 1 | Select stencil field (32-bit format only) |
| req_x | input | CW | Pixel x within the window |
| req_y | input | CW | Pixel y within the window |
| req_wdata | input | 32 | Write value (field in low bits) |
| cfg_fmt32 | input | 1 | 1 = packed 32-bit depth-stencil, 0 = 16-bit depth |
| cfg_linear | input | 1 | 1 = row-major layout, 0 = tiled layout |
| cfg_pitch | input | CW | Surface pitch in pixels |
| cfg_org_x | input | CW | Window origin x |
| cfg_org_y | input | CW | Window origin y |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result, zero-extended |
| busy | output | 1 | Read-modify-write in progress |

## Verification
A fault in the sequencer shows within two cycles of accepting a packed write. Either the write-back never appears after the read, or busy stays up and req_ready never returns, and a held request then stalls for good. A stale operation register shows in the write-back word: the wrong byte of the merged word is taken from memory or from the request, and the error can be seen in the very cycle of the write-back. A wrong lane or format capture shows in the next cycle's rd_data, and a fault in any of the address maps shows at once on mem_addr for the same request.

// File: rtl/zs_pkg.sv
package zs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_MERGE = 2'd2
   } zs_state_e;

   typedef struct packed {
      logic stencil;
      logic fmt32;
      logic lane;
   } zs_rsel_t;

endpackage

// File: rtl/zs_tile_map.sv
module zs_tile_map #(
   parameter int CW   = 12,
   parameter int AW   = 28,
   parameter bit WIDE = 1'b1
) (
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   input  logic [CW-1:0] pitch,
   output logic [AW-1:0] addr
);
   localparam int XSH = WIDE ? 4 : 5;

   if (CW < 6) begin : g_bad_cw
      $error("zs_tile_map: CW must be at least 6");
   end
   if (AW < 14) begin : g_bad_aw
      $error("zs_tile_map: AW must be at least 14");
   end

   logic [AW-1:0] blk_row;
   logic [AW-1:0] blk_col;
   logic [AW-1:0] blk_per_row;
   logic [AW-1:0] blk;
   logic          unused_blk_hi;

   assign blk_row     = AW'(y >> 4);
   assign blk_col     = AW'(x >> XSH);
   assign blk_per_row = AW'(pitch >> XSH);
   assign blk         = blk_row * blk_per_row + blk_col;
   assign unused_blk_hi = ^blk[AW-1:AW-10];

   if (WIDE) begin : g_map32
      assign addr = {blk[AW-11:2], x[3] ^ y[4], y[3], blk[1:0],
                     x[4] ^ y[2], y[1:0], x[2:0], 2'b00};
   end else begin : g_map16
      assign addr = {blk[AW-11:2], x[4] ^ y[4], y[3], blk[1:0],
                     x[3], y[2:0], x[2:0], 1'b0};
   end

endmodule

// File: rtl/zs_addr_xlate.sv
module zs_addr_xlate #(
   parameter int CW = 12,
   parameter int AW = 28
) (
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   input  logic [CW-1:0] org_x,
   input  logic [CW-1:0] org_y,
   input  logic [CW-1:0] pitch,
   input  logic          fmt32,
   input  logic          linear,
   output logic [AW-1:0] addr
);
   localparam int NMAP = 2;

   if (AW < 2 * CW + 3) begin : g_bad_aw
      $error("zs_addr_xlate: AW too small for CW");
   end

   logic [CW-1:0] xe;
   logic [CW-1:0] ye;
   logic [AW-1:0] tile_addr [NMAP];
   logic [AW-1:0] pix_index;
   logic [AW-1:0] lin_addr;

   assign xe = x + org_x;
   assign ye = y + org_y;

   for (genvar v = 0; v < NMAP; v++) begin : g_map
      zs_tile_map #(
         .CW  (CW),
         .AW  (AW),
         .WIDE(v == 1)
      ) u_map (
         .x    (xe),
         .y    (ye),
         .pitch(pitch),
         .addr (tile_addr[v])
      );
   end

   assign pix_index = AW'(xe) + AW'(ye) * AW'(pitch);
   assign lin_addr  = fmt32 ? (pix_index << 2) : (pix_index << 1);
   assign addr      = linear ? lin_addr : tile_addr[fmt32];

endmodule

// File: rtl/zs_field_unit.sv
module zs_field_unit
   import zs_pkg::*;
#(
   parameter int DW = 24,
   parameter int SW = 8
) (
   input  logic [DW+SW-1:0] old_word,
   input  logic [DW-1:0]    new_field,
   input  logic             sel_stencil,
   output logic [DW+SW-1:0] merged,
   input  logic [DW+SW-1:0] rword,
   input  zs_rsel_t         rsel,
   output logic [DW+SW-1:0] rfield
);
   localparam int WW = DW + SW;
   localparam int HW = WW / 2;

   if (WW != 32 || DW < SW) begin : g_bad_width
      $error("zs_field_unit: depth plus stencil must fill 32 bits");
   end

   always_comb begin
      if (sel_stencil) merged = {new_field[SW-1:0], old_word[DW-1:0]};
      else             merged = {old_word[WW-1:DW], new_field};
   end

   always_comb begin
      if (rsel.fmt32) begin
         if (rsel.stencil) rfield = WW'(rword[WW-1:DW]);
         else              rfield = WW'(rword[DW-1:0]);
      end else begin
         rfield = rsel.lane ? WW'(rword[WW-1:HW]) : WW'(rword[HW-1:0]);
      end
   end

endmodule

// File: rtl/zs_access_unit.sv
module zs_access_unit
   import zs_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic          req_stencil,
   input  logic [CW-1:0] req_x,
   input  logic [CW-1:0] req_y,
   input  logic [31:0]   req_wdata,
   input  logic          cfg_fmt32,
   input  logic          cfg_linear,
   input  logic [CW-1:0] cfg_pitch,
   input  logic [CW-1:0] cfg_org_x,
   input  logic [CW-1:0] cfg_org_y,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          rd_valid,
   output logic [31:0]   rd_data,
   output logic          busy
);
   localparam int DW = 24;
   localparam int SW = 8;
   localparam logic [3:0] BE_LO  = 4'b0011;
   localparam logic [3:0] BE_HI  = 4'b1100;
   localparam logic [3:0] BE_ALL = 4'b1111;

   zs_state_e     state_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wfield_q;
   logic          stn_q;
   zs_rsel_t      rsel_q;
   logic          rd_valid_q;

   logic [AW-1:0] xl_addr;
   logic          accept;
   logic          needs_rmw;
   logic          stn_eff;
   logic [31:0]   merged_word;
   logic [31:0]   read_field;
   logic          unused_wd_hi;

   assign unused_wd_hi = ^req_wdata[31:DW];

   zs_addr_xlate #(
      .CW(CW),
      .AW(AW)
   ) u_xlate (
      .x     (req_x),
      .y     (req_y),
      .org_x (cfg_org_x),
      .org_y (cfg_org_y),
      .pitch (cfg_pitch),
      .fmt32 (cfg_fmt32),
      .linear(cfg_linear),
      .addr  (xl_addr)
   );

   zs_field_unit #(
      .DW(DW),
      .SW(SW)
   ) u_field (
      .old_word   (mem_rdata),
      .new_field  (wfield_q),
      .sel_stencil(stn_q),
      .merged     (merged_word),
      .rword      (mem_rdata),
      .rsel       (rsel_q),
      .rfield     (read_field)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign busy      = (state_q != ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign needs_rmw = req_write && cfg_fmt32;
   assign stn_eff   = req_stencil && cfg_fmt32;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_q     <= '0;
         wfield_q   <= '0;
         stn_q      <= 1'b0;
         rsel_q     <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= accept && !req_write;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  rsel_q <= '{stencil: stn_eff, fmt32: cfg_fmt32, lane: xl_addr[1]};
                  if (needs_rmw) begin
                     addr_q   <= xl_addr;
                     wfield_q <= req_wdata[DW-1:0];
                     stn_q    <= req_stencil;
                     state_q  <= ST_READ;
                  end
               end
            end
            ST_READ:  state_q <= ST_MERGE;
            ST_MERGE: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = xl_addr;
      mem_be    = BE_ALL;
      mem_wdata = '0;
      unique case (state_q)
         ST_IDLE: begin
            mem_en    = accept && !needs_rmw;
            mem_we    = accept && !needs_rmw && req_write;
            mem_addr  = xl_addr;
            mem_be    = req_write ? (xl_addr[1] ? BE_HI : BE_LO) : BE_ALL;
            mem_wdata = {2{req_wdata[15:0]}};
         end
         ST_READ: begin
            mem_en   = 1'b1;
            mem_addr = addr_q;
         end
         ST_MERGE: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = addr_q;
            mem_wdata = merged_word;
         end
         default: begin
            mem_en = 1'b0;
         end
      endcase
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = read_field;

   // R9: a read issued under busy is followed by a full-word write-back
   assert_rmw_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && busy) |=> (mem_en && mem_we && busy && mem_be == BE_ALL));

   // R5: writes issued outside busy touch one half and replicate the data
   assert_lane_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && !busy) |->
         ((mem_be == BE_LO || mem_be == BE_HI) && mem_wdata[31:16] == mem_wdata[15:0]));

   // R7: stencil write-back keeps the stored depth bits
   assert_keep_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && busy && stn_q) |-> (mem_wdata[DW-1:0] == mem_rdata[DW-1:0]));

   // R6: depth write-back keeps the stored stencil byte
   assert_keep_stencil_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && busy && !stn_q) |-> (mem_wdata[31:DW] == mem_rdata[31:DW]));

   // R8: a result appears only after a plain read was issued
   assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_en && !mem_we && !busy));

   // R9: no acceptance while a read-modify-write is running
   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !(rd_valid && $past(busy) && !$past(req_ready)));

endmodule

// File: tb/zs_access_unit_bench.sv
module zs_access_unit_bench;
   localparam int CW = 12;
   localparam int AW = 28;
   localparam int NV = 10;

   typedef struct packed {
      int fmt32;
      int lin;
      int x;
      int y;
      int ox;
      int oy;
      int pitch;
      int exp;
   } vec_t;

   // fmt32 lin x y ox oy pitch expected-address
   localparam vec_t VEC [NV] = '{
      '{1, 1,   3,  2,  0, 0, 100,   812},   // R2
      '{0, 1,   5,  1,  2, 3,  64,   526},   // R2 R1
      '{1, 0,   0,  0,  0, 0,  64,     0},   // R3
      '{1, 0,  21,  6,  0, 0,  64,   340},   // R3
      '{1, 0,   9, 27,  0, 0,  32,  1636},   // R3
      '{1, 0,  40, 20,  0, 0, 128,  8832},   // R3
      '{0, 0,  13,  5,  0, 0,  64,   218},   // R4
      '{0, 0,  50, 19,  0, 0,  64,   820},   // R4
      '{0, 0,   1,  2, 16, 8,  32,  3106},   // R4 R1
      '{0, 0, 130, 40,  0, 0, 256, 21508}    // R4
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic          req_stencil = 1'b0;
   logic [CW-1:0] req_x = '0;
   logic [CW-1:0] req_y = '0;
   logic [31:0]   req_wdata = '0;
   logic          cfg_fmt32 = 1'b0;
   logic          cfg_linear = 1'b1;
   logic [CW-1:0] cfg_pitch = 12'd16;
   logic [CW-1:0] cfg_org_x = '0;
   logic [CW-1:0] cfg_org_y = '0;
   logic          mem_en;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic          rd_valid;
   logic [31:0]   rd_data;
   logic          busy;

   int checks = 0;
   int errors = 0;
   logic [31:0] mem [4096];

   always #5 clk = ~clk;

   zs_access_unit #(.CW(CW), .AW(AW)) u_zs_access_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_stencil,
      .req_x, .req_y, .req_wdata, .cfg_fmt32, .cfg_linear, .cfg_pitch,
      .cfg_org_x, .cfg_org_y, .mem_en, .mem_we, .mem_addr, .mem_be,
      .mem_wdata, .mem_rdata, .rd_valid, .rd_data, .busy
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[13:2]];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic st, input int x, input int y,
                        input logic [31:0] d);
      @(negedge clk);
      req_valid   = 1'b1;
      req_write   = wr;
      req_stencil = st;
      req_x       = CW'(x);
      req_y       = CW'(y);
      req_wdata   = d;
      #1;
   endtask

   task automatic finish_req;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
   endtask

   task automatic wait_cycle;
      @(negedge clk);
      #1;
   endtask

   task automatic rd_check(input string req, input logic st, input int x,
                           input logic [31:0] exp);
      drive(1'b0, st, x, 0, 32'h0);
      finish_req();
      chk(req, {31'b0, rd_valid}, 32'd1);
      chk(req, rd_data, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
      mem[0] = 32'hAAAA5555;
      mem[2] = 32'hC3112233;

      // R11: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R11 busy", {31'b0, busy}, 32'd0);
      chk("R11 ready", {31'b0, req_ready}, 32'd1);
      chk("R11 rd_valid", {31'b0, rd_valid}, 32'd0);
      chk("R11 mem_en", {31'b0, mem_en}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cycle();
      chk("R11 busy after release", {31'b0, busy}, 32'd0);
      chk("R11 mem_en idle", {31'b0, mem_en}, 32'd0);

      // R1 R2 R3 R4: address map vectors
      for (int v = 0; v < NV; v++) begin
         cfg_fmt32  = VEC[v].fmt32[0];
         cfg_linear = VEC[v].lin[0];
         cfg_pitch  = CW'(VEC[v].pitch);
         cfg_org_x  = CW'(VEC[v].ox);
         cfg_org_y  = CW'(VEC[v].oy);
         drive(1'b0, 1'b0, VEC[v].x, VEC[v].y, 32'h0);
         chk($sformatf("R1/R2/R3/R4 vector %0d mem_en", v), {31'b0, mem_en}, 32'd1);
         chk($sformatf("R1/R2/R3/R4 vector %0d addr", v), 32'(mem_addr), VEC[v].exp);
         finish_req();
         wait_cycle();
         chk("R8 rd_valid single pulse", {31'b0, rd_valid}, 32'd0);
      end

      // 16-bit format, linear, pitch 16
      cfg_fmt32 = 1'b0; cfg_linear = 1'b1; cfg_pitch = 12'd16;
      cfg_org_x = '0; cfg_org_y = '0;

      // R5: upper-lane write, direct, replicated
      drive(1'b1, 1'b0, 1, 0, 32'h0000_1234);
      chk("R5 write issued", {30'b0, mem_en, mem_we}, 32'd3);
      chk("R5 be upper", {28'b0, mem_be}, 32'h0000_000C);
      chk("R5 wdata replicated", mem_wdata, 32'h1234_1234);
      chk("R5 no busy", {31'b0, busy}, 32'd0);
      finish_req();
      chk("R5 still no busy", {31'b0, busy}, 32'd0);
      rd_check("R8 upper half read", 1'b0, 1, 32'h0000_1234);
      rd_check("R5 R8 lower half kept", 1'b0, 0, 32'h0000_5555);

      // R10: stencil flag has no effect in 16-bit format
      rd_check("R10 stencil flag read", 1'b1, 1, 32'h0000_1234);
      drive(1'b1, 1'b1, 0, 0, 32'h0000_7777);
      chk("R10 write direct", {30'b0, mem_en, mem_we}, 32'd3);
      chk("R10 be lower", {28'b0, mem_be}, 32'h0000_0003);
      chk("R10 no busy", {31'b0, busy}, 32'd0);
      finish_req();
      rd_check("R10 lower half written", 1'b0, 0, 32'h0000_7777);
      rd_check("R10 upper half kept", 1'b0, 1, 32'h0000_1234);

      // packed 32-bit format, linear: x=2 -> byte 8, word 2
      cfg_fmt32 = 1'b1;

      // R6 R9: depth write read-modify-write
      drive(1'b1, 1'b0, 2, 0, 32'h77AB_CDEF);
      chk("R9 nothing issued at accept", {31'b0, mem_en}, 32'd0);
      finish_req();
      chk("R9 busy in read", {31'b0, busy}, 32'd1);
      chk("R9 not ready in read", {31'b0, req_ready}, 32'd0);
      chk("R9 read issued", {30'b0, mem_en, mem_we}, 32'd2);
      chk("R9 read addr", 32'(mem_addr), 32'd8);
      wait_cycle();
      chk("R9 busy in write-back", {31'b0, busy}, 32'd1);
      chk("R9 write-back issued", {30'b0, mem_en, mem_we}, 32'd3);
      chk("R9 write-back be", {28'b0, mem_be}, 32'h0000_000F);
      chk("R6 merged word", mem_wdata, 32'hC3AB_CDEF);
      wait_cycle();
      chk("R9 idle again", {30'b0, busy, req_ready}, 32'd1);
      rd_check("R8 R6 depth read", 1'b0, 2, 32'h00AB_CDEF);
      rd_check("R8 R6 stencil kept", 1'b1, 2, 32'h0000_00C3);

      // R7 R9: stencil write with a request held during busy
      drive(1'b1, 1'b1, 2, 0, 32'h1234_565A);
      @(posedge clk);
      @(negedge clk);
      req_write = 1'b0; req_stencil = 1'b1; req_wdata = 32'h0;
      #1;
      chk("R9 held request stalled", {31'b0, req_ready}, 32'd0);
      chk("R9 read under busy", {30'b0, mem_en, mem_we}, 32'd2);
      wait_cycle();
      chk("R9 no result during stall", {31'b0, rd_valid}, 32'd0);
      chk("R7 merged word", mem_wdata, 32'h5AAB_CDEF);
      wait_cycle();
      chk("R9 held request now issued", {30'b0, mem_en, mem_we}, 32'd2);
      finish_req();
      chk("R9 R8 held read valid", {31'b0, rd_valid}, 32'd1);
      chk("R7 stencil read", rd_data, 32'h0000_005A);
      rd_check("R7 depth kept", 1'b0, 2, 32'h00AB_CDEF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule